// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Slice

This block models a small programmable array logic device. A set of dedicated data inputs, together with one feedback signal per output, forms the input plane. Every product term can use each plane signal in true form, complemented form, both or neither. Each output sums its own fixed group of product terms, and the groups differ in size from output to output. The summed value then passes through a macrocell. The macrocell can invert the value, hold it in a flip-flop or pass it straight through, and return the registered value to the input plane. A configuration with feedback can therefore hold a small state machine.

The whole personality of the slice lives in one configuration vector. This vector is loaded serially at one bit per clock while `cfg_load` is high. The shift path takes a bit on every cycle that `cfg_load` is high and applies no back-pressure, so the loader must not pause. There is no valid/ready handshake because nothing in the slice can stall. The data inputs and outputs are plain level signals.

Top module: `sop_slice`

## Requirements
- R1: While `cfg_load` is high, each rising edge shifts `cfg_bit` into the top of the configuration vector and moves the vector down by one bit. After CFG_BITS such shifts, the first bit sent occupies index 0. With the defaults, CFG_BITS is 316: 24 terms of 13 bits each, plus 4 macrocell bits.
- R2: Term t owns configuration bits t*TB to t*TB+TB-1, where TB = 2*(N_IN+N_OUT)+1. Within a term, bit 2i requires plane signal i to be 1 and bit 2i+1 requires it to be 0. The term is the AND of all its selected literals, so setting both bits of the same signal forces the term to 0.
- R3: Bit TB-1 of a term disables it and forces it to 0. An enabled term with no literal selected evaluates to 1.
- R4: Plane signals 0 to N_IN-1 are `din`. Plane signal N_IN+k is the feedback value of output k.
- R5: Output k sums a group of TMIN + k*(TMAX-TMIN)/(N_OUT-1) terms, giving 8 and 16 with the defaults. The groups are laid out in output order starting at term 0. A term outside a group has no effect on that output.
- R6: Macrocell k uses configuration bits TERM_BITS+2k and TERM_BITS+2k+1. Bit 0 selects registered mode. Bit 1 makes the output active-low by inverting the summed value.
- R7: In combinational mode, `dout[k]` follows the post-polarity sum in the same cycle. In registered mode, `dout[k]` is the macrocell flip-flop.
- R8: On every rising edge with `cfg_load` low, each macrocell flip-flop captures its post-polarity sum, in either mode. The feedback value of output k is always this flip-flop.
- R9: A synchronous reset clears the configuration vector and all macrocell flip-flops. With the cleared configuration, every output is combinational and reads 1 whenever the slice is not loading.
- R10: While `cfg_load` is high, every `dout` bit is 0 and the macrocell flip-flops hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Configuration shift enable |
| cfg_bit | input | 1 | Serial configuration data |
| din | input | N_IN | Dedicated plane inputs |
| dout | output | N_OUT | Macrocell outputs |

## Verification
A combinational output responds to `din` within the same cycle. A registered output, and every feedback value, changes one rising edge after the sum it captures. A configuration bit takes effect one edge after it is shifted. The bench drives its inputs shortly after each falling edge and updates its behavioural model on each rising edge. It compares every output at the next falling edge, so each result has a settled half cycle and each registered value has crossed exactly one edge. The counter program is checked on consecutive cycles from the first edge after loading ends. The XOR and constant programs are checked one falling edge after each new input pattern.

// File: rtl/sop_pkg.sv
package sop_pkg;

  typedef struct packed {
    logic inv;
    logic reg_en;
  } mc_cfg_t;

  function automatic int grp_size(int k, int n_out, int tmin, int tmax);
    if (n_out < 2) return tmax;
    return tmin + (k * (tmax - tmin)) / (n_out - 1);
  endfunction

  function automatic int grp_base(int k, int n_out, int tmin, int tmax);
    int acc;
    acc = 0;
    for (int j = 0; j < k; j++) acc += grp_size(j, n_out, tmin, tmax);
    return acc;
  endfunction

endpackage

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] cfg
);

  always_ff @(posedge clk) begin
    if (rst) cfg <= '0;
    else if (shift_en) cfg <= {bit_in, cfg[W-1:1]};
  end

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int NP    = 6,
  parameter int NTERM = 24,
  localparam int TB   = 2 * NP + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NP-1:0]       plane,
  input  logic [NTERM*TB-1:0] tcfg,
  output logic [NTERM-1:0]    terms
);

  for (genvar t = 0; t < NTERM; t++) begin : g_term
    logic [TB-1:0] c;
    logic [NP-1:0] want_hi, want_lo, miss;

    assign c = tcfg[t*TB +: TB];

    always_comb begin
      for (int i = 0; i < NP; i++) begin
        want_hi[i] = c[2*i];
        want_lo[i] = c[2*i+1];
      end
    end

    assign miss     = (want_hi & ~plane) | (want_lo & plane);
    assign terms[t] = ~c[TB-1] & ~(|miss);

    AST_CONFLICT_ZERO: assert property (@(posedge clk) disable iff (rst)
      (|(want_hi & want_lo)) |-> !terms[t]); // R2
    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (rst)
      c[TB-1] |-> !terms[t]); // R3
  end

endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell #(
  parameter int NT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic [NT-1:0]     terms,
  input  sop_pkg::mc_cfg_t  mcfg,
  output logic              fb,
  output logic              out
);

  logic sum, pol, q;

  assign sum = |terms;
  assign pol = sum ^ mcfg.inv;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else if (!hold) q <= pol;
  end

  assign fb  = q;
  assign out = mcfg.reg_en ? q : pol;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(fb)); // R10

endmodule

// File: rtl/sop_slice.sv
module sop_slice #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 2,
  parameter int TMIN  = 8,
  parameter int TMAX  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic             cfg_bit,
  input  logic [N_IN-1:0]  din,
  output logic [N_OUT-1:0] dout
);

  localparam int NP        = N_IN + N_OUT;
  localparam int TB        = 2 * NP + 1;
  localparam int NTERM     = sop_pkg::grp_base(N_OUT, N_OUT, TMIN, TMAX);
  localparam int TERM_BITS = NTERM * TB;
  localparam int CFG_BITS  = TERM_BITS + 2 * N_OUT;

  logic [CFG_BITS-1:0] cfg_q;
  logic [NTERM-1:0]    terms;
  logic [N_OUT-1:0]    fb, mc_out;
  logic [NP-1:0]       plane;

  assign plane = {fb, din};

  sop_cfg_chain #(.W(CFG_BITS)) u_chain (
    .clk(clk), .rst(rst), .shift_en(cfg_load), .bit_in(cfg_bit), .cfg(cfg_q)
  );

  sop_and_plane #(.NP(NP), .NTERM(NTERM)) u_plane (
    .clk(clk), .rst(rst), .plane(plane),
    .tcfg(cfg_q[TERM_BITS-1:0]), .terms(terms)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    localparam int BASE = sop_pkg::grp_base(k, N_OUT, TMIN, TMAX);
    localparam int NT   = sop_pkg::grp_size(k, N_OUT, TMIN, TMAX);

    sop_macrocell #(.NT(NT)) u_mc (
      .clk(clk), .rst(rst), .hold(cfg_load),
      .terms(terms[BASE +: NT]),
      .mcfg(sop_pkg::mc_cfg_t'(cfg_q[TERM_BITS + 2*k +: 2])),
      .fb(fb[k]), .out(mc_out[k])
    );

    assign dout[k] = cfg_load ? 1'b0 : mc_out[k];
  end

  AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    cfg_load |-> (dout == '0)); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (fb == '0)); // R9

endmodule

// File: tb/sim_sop_slice.sv
`timescale 1ns/100ps
module sim_sop_slice;

  localparam int NIN   = 4;
  localparam int NOUT  = 2;
  localparam int NP    = NIN + NOUT;
  localparam int TB    = 2 * NP + 1;
  localparam int NTERM = 24;
  localparam int TBITS = NTERM * TB;
  localparam int CFGW  = TBITS + 2 * NOUT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_load = 1'b0;
  logic cfg_bit = 1'b0;
  logic [NIN-1:0]  din = '0;
  logic [NOUT-1:0] dout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit [CFGW-1:0] img;
  bit [CFGW-1:0] mcfg = '0;
  bit [NOUT-1:0] mq = '0;

  always #2.5 clk = ~clk;

  sop_slice u0 (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_bit(cfg_bit),
    .din(din), .dout(dout)
  );

  function automatic int gsize(int k);
    return 8 + (k * 8) / (NOUT - 1);
  endfunction

  function automatic int gbase(int k);
    int a = 0;
    for (int j = 0; j < k; j++) a += gsize(j);
    return a;
  endfunction

  function automatic bit mterm(int t);
    int off = t * TB;
    if (mcfg[off + 2*NP]) return 1'b0;
    for (int i = 0; i < NP; i++) begin
      bit v = (i < NIN) ? din[i] : mq[i - NIN];
      if (mcfg[off + 2*i] && !v) return 1'b0;
      if (mcfg[off + 2*i + 1] && v) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic bit mpol(int k);
    bit s = 1'b0;
    for (int n = 0; n < gsize(k); n++) s |= mterm(gbase(k) + n);
    return s ^ mcfg[TBITS + 2*k + 1];
  endfunction

  always @(posedge clk) begin
    bit [NOUT-1:0] nq;
    for (int k = 0; k < NOUT; k++) nq[k] = mpol(k);
    if (rst) begin
      mq = '0;
      mcfg = '0;
    end else if (cfg_load) begin
      mcfg = {cfg_bit, mcfg[CFGW-1:1]};
    end else begin
      mq = nq;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [NOUT-1:0] e;
      for (int k = 0; k < NOUT; k++)
        e[k] = cfg_load ? 1'b0 : (mcfg[TBITS + 2*k] ? mq[k] : mpol(k));
      chk(cfg_load ? "R10 model" : "R7 model", 32'(dout), 32'(e));
    end
  end

  task automatic img_clear();
    img = '0;
    for (int t = 0; t < NTERM; t++) img[t*TB + 2*NP] = 1'b1;
  endtask

  task automatic lit(int t, int i, bit comp);
    img[t*TB + 2*i + int'(comp)] = 1'b1;
    img[t*TB + 2*NP] = 1'b0;
  endtask

  task automatic en_term(int t);
    img[t*TB + 2*NP] = 1'b0;
  endtask

  task automatic mc(int k, bit r, bit inv);
    img[TBITS + 2*k] = r;
    img[TBITS + 2*k + 1] = inv;
  endtask

  // Called just after a falling edge; returns just after a falling edge.
  task automatic load_img();
    for (int i = 0; i < CFGW; i++) begin
      cfg_load = 1'b1;
      cfg_bit = img[i];
      @(negedge clk);
      if (i == 3) chk("R10 outputs low while loading", 32'(dout), 32'h0);
      #1;
    end
    cfg_load = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset config gives all ones", 32'(dout), 32'h3);
    #1;
    rst = 1'b0;

    // Two-bit counter: out0 toggles, out1 flips when out0 is 1.
    img_clear();
    lit(0, NIN + 0, 1'b1);
    lit(8, NIN + 1, 1'b0);
    lit(8, NIN + 0, 1'b1);
    lit(9, NIN + 1, 1'b1);
    lit(9, NIN + 0, 1'b0);
    mc(0, 1'b1, 1'b0);
    mc(1, 1'b1, 1'b0);
    load_img();
    for (int c = 1; c <= 6; c++) begin
      din = 4'(c * 5);
      @(negedge clk);
      chk("R8 R4 counter feedback", 32'(dout), 32'(c % 4));
      chk("R7 registered output", 32'(dout[0]), 32'(c % 2));
      #1;
    end

    // XOR on out0, inverted XOR on out1, plus a conflicting term on out1.
    img_clear();
    lit(0, 0, 1'b0); lit(0, 1, 1'b1);
    lit(1, 0, 1'b1); lit(1, 1, 1'b0);
    lit(8, 0, 1'b0); lit(8, 1, 1'b1);
    lit(9, 0, 1'b1); lit(9, 1, 1'b0);
    lit(10, 2, 1'b0); lit(10, 2, 1'b1);
    mc(0, 1'b0, 1'b0);
    mc(1, 1'b0, 1'b1);
    load_img();
    for (int p = 0; p < 16; p++) begin
      bit x;
      din = 4'(p);
      x = din[0] ^ din[1];
      @(negedge clk);
      chk("R1 R2 xor output", 32'(dout[0]), 32'(x));
      chk("R6 active-low xnor", 32'(dout[1]), 32'(!x));
      #1;
    end

    // Empty enabled term on out0 only; out1 group entirely disabled.
    img_clear();
    en_term(0);
    mc(0, 1'b0, 1'b0);
    mc(1, 1'b0, 1'b0);
    load_img();
    for (int p = 0; p < 4; p++) begin
      din = 4'(p * 3 + 1);
      @(negedge clk);
      chk("R3 empty term is one", 32'(dout[0]), 32'h1);
      chk("R5 other group unaffected", 32'(dout[1]), 32'h0);
      #1;
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule